// File: doc/BRIEF.md
# Dual-MISO LSB-First SPI Master

This block is the serial master that talks to a sensor layer. Bytes to be sent arrive on an AXI-Stream slave port. Each byte goes out on a single MOSI line, least significant bit first. The master produces the serial clock by gating its own input clock, so the serial clock toggles only while bits are moving. The sensor answers on two MISO lines, and each pulse of the serial clock yields two received bits. One byte sent therefore brings back two received bytes, which leave on an AXI-Stream master port, the earlier byte first.

A force input lets the master keep the link running without any data to send. It then transmits zero bytes so that the sensor can be drained. A drop input throws away the received data, for example while a configuration is being written. When the output stream stops accepting bytes, the master freezes the serial clock before any received byte could be lost.

The block also produces the single chip-select line that three layers share. Software can pull the line low through a per-layer select bit. Any layer with automatic reading enabled keeps the line low.

Top module: `dmspi_master`

## Requirements
- R1: In the cycle after reset `cs_n_o` is 1, `m_valid_o` is 0, `mosi_o` is 0 and `sclk_o` is low.
- R2: A byte costs exactly eight serial-clock pulses. A pulse starts only when a byte is offered on the slave stream or `force_i` is 1, so with neither the serial clock stays low. `sclk_o` is high only during the high phase of `clk`.
- R3: MOSI is updated on each rising serial-clock edge and is sent bit 0 first.
- R4: `miso0_i` and `miso1_i` are sampled on the falling serial-clock edge. For pulse k of a byte, `miso0_i` fills bit 2k and `miso1_i` fills bit 2k+1 of a 16-bit word. Bits 7:0 of that word are output first and bits 15:8 second.
- R5: With `force_i` at 1 and nothing offered on the slave stream, 0x00 bytes are sent while reception goes on. A byte offered on the slave stream in the same cycle takes precedence.
- R6: The output holds at most one unaccepted byte. While it holds one, the serial clock stops before the pulse that would complete the next byte, and it resumes once the byte is taken. Nothing is lost.
- R7: While `miso_off_i` is 1, received bytes are discarded and `m_valid_o` never rises. Transmission continues.
- R8: When no autoread enable is set, `cs_n_o` goes to 0 one cycle after any `cs_sel_i` bit is 1, and returns to 1 one cycle after all bits are 0.
- R9: While any `autoread_i` bit is 1, `cs_n_o` is 0 regardless of `cs_sel_i`. It returns to 1 one cycle after every autoread bit has cleared, provided no select bit is set.
- R10: While `m_valid_o` is 1 and `m_ready_i` is 0, `m_data_o` and `m_valid_o` hold steady.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the source of the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid_i | input | 1 | A byte to send is offered |
| s_ready_o | output | 1 | The offered byte is taken this cycle |
| s_data_i | input | BYTE_W | Byte to send |
| m_valid_o | output | 1 | A received byte is presented |
| m_ready_i | input | 1 | The downstream side accepts the presented byte |
| m_data_o | output | BYTE_W | Received byte |
| force_i | input | 1 | Keep clocking with zero bytes when no byte is offered |
| miso_off_i | input | 1 | Discard received bytes |
| cs_sel_i | input | LAYERS | Per-layer software chip-select request |
| autoread_i | input | LAYERS | Per-layer automatic-read enable |
| sclk_o | output | 1 | Gated serial clock |
| cs_n_o | output | 1 | Shared chip select, active low |
| mosi_o | output | 1 | Serial data to the sensor |
| miso0_i | input | 1 | Serial data from the sensor, even bit positions |
| miso1_i | input | 1 | Serial data from the sensor, odd bit positions |

## Verification
Two pairs of events can land in the same cycle. In the first, a stream byte and the force request are both present while the master is idle. The bench raises both together and checks that the byte seen on MOSI is the stream byte, not zero, and that exactly eight pulses follow. In the second, the pulse that would complete a byte comes due while the output still holds an unaccepted byte. The bench holds `m_ready_i` low through a transfer and checks that the pulse count stops at seven with the first byte held steady. It then releases the stream and checks that the eighth pulse arrives and that both bytes come out in order.

// File: rtl/dmspi_pkg.sv
package dmspi_pkg;

    localparam int unsigned DEF_BYTE_W = 8;
    localparam int unsigned DEF_LAYERS = 3;

    // Where the byte currently being clocked out came from
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_STREAM = 2'd1,
        SRC_NULL   = 2'd2
    } src_e;

    // Two bits captured on one falling serial edge
    typedef struct packed {
        logic odd;
        logic even;
    } lane_pair_t;

    // One requested serial pulse and the MOSI bit it carries
    typedef struct packed {
        logic fire;
        logic bit_val;
    } pulse_req_t;

    // True for a pulse index whose capture completes a received byte
    function automatic logic closes_byte(input int unsigned idx,
                                         input int unsigned half,
                                         input int unsigned width);
        return (idx == half - 1) || (idx == width - 1);
    endfunction

endpackage

// File: rtl/dmspi_sched.sv
module dmspi_sched
    import dmspi_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              force_en,
    input  logic              room,
    output pulse_req_t        req,
    output logic              mosi
);

    localparam int unsigned HALF  = BYTE_W / 2;
    localparam int unsigned IDX_W = $clog2(BYTE_W);

    logic [IDX_W-1:0]  idx_q;
    logic              loaded_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] cur_byte;
    pulse_req_t        req_q;
    logic              mosi_q;
    src_e              src;
    logic              have;
    logic              closing;
    logic              go;

    always_comb begin
        if (loaded_q)      src = SRC_NONE;
        else if (s_valid)  src = SRC_STREAM;
        else if (force_en) src = SRC_NULL;
        else               src = SRC_NONE;

        if (loaded_q)               cur_byte = tx_q;
        else if (src == SRC_STREAM) cur_byte = s_data;
        else                        cur_byte = '0;

        have    = loaded_q || (src != SRC_NONE);
        closing = closes_byte(int'(idx_q), HALF, BYTE_W);
        go      = have && (!closing || room);
    end

    assign s_ready = (src == SRC_STREAM) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            loaded_q <= 1'b0;
            tx_q     <= '0;
            req_q    <= '0;
            mosi_q   <= 1'b0;
        end else begin
            // the pulse requested last cycle rises now: present its bit
            if (req_q.fire) begin
                mosi_q <= req_q.bit_val;
            end
            req_q.fire    <= go;
            req_q.bit_val <= cur_byte[idx_q];
            if (go) begin
                tx_q <= cur_byte;
                if (idx_q == IDX_W'(BYTE_W - 1)) begin
                    idx_q    <= '0;
                    loaded_q <= 1'b0;
                end else begin
                    idx_q    <= idx_q + 1'b1;
                    loaded_q <= 1'b1;
                end
            end
        end
    end

    assign req  = req_q;
    assign mosi = mosi_q;

endmodule

// File: rtl/dmspi_phy.sv
module dmspi_phy
    import dmspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       miso0,
    input  logic       miso1,
    output logic       sclk,
    output logic       cap_vld,
    output lane_pair_t cap
);

    logic       en_q;
    logic       cap_vld_q;
    lane_pair_t cap_q;

    // Enable changes only while clk is low, so the gated clock is clean.
    // The same edge is the falling serial edge of the pulse that just ran.
    always_ff @(negedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            cap_vld_q <= 1'b0;
            cap_q     <= '0;
        end else begin
            cap_vld_q <= en_q;
            if (en_q) begin
                cap_q.even <= miso0;
                cap_q.odd  <= miso1;
            end
            en_q <= fire;
        end
    end

    assign sclk    = clk & en_q;
    assign cap_vld = cap_vld_q;
    assign cap     = cap_q;

endmodule

// File: rtl/dmspi_assemble.sv
module dmspi_assemble
    import dmspi_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_vld,
    input  lane_pair_t        cap,
    input  logic              drop,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [BYTE_W-1:0] m_data,
    output logic              room,
    output logic              push
);

    localparam int unsigned HALF   = BYTE_W / 2;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);
    localparam int unsigned POS_W  = CNT_W + 1;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_n;
    logic [POS_W-1:0]  pos_even;
    logic [POS_W-1:0]  pos_odd;
    logic              done_lo;
    logic              done_hi;
    logic [BYTE_W-1:0] byte_n;
    logic              m_valid_q;
    logic [BYTE_W-1:0] m_data_q;

    always_comb begin
        pos_even         = {cnt_q, 1'b0};
        pos_odd          = {cnt_q, 1'b1};
        word_n           = word_q;
        word_n[pos_even] = cap.even;
        word_n[pos_odd]  = cap.odd;
        done_lo          = cap_vld && (cnt_q == CNT_W'(HALF - 1));
        done_hi          = cap_vld && (cnt_q == CNT_W'(BYTE_W - 1));
        byte_n           = done_hi ? word_n[BYTE_W +: BYTE_W] : word_n[BYTE_W-1:0];
        push             = (done_lo || done_hi) && !drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            word_q    <= '0;
            m_valid_q <= 1'b0;
            m_data_q  <= '0;
        end else begin
            if (cap_vld) begin
                word_q <= word_n;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (push) begin
                m_valid_q <= 1'b1;
                m_data_q  <= byte_n;
            end else if (m_ready) begin
                m_valid_q <= 1'b0;
            end
        end
    end

    assign m_valid = m_valid_q;
    assign m_data  = m_data_q;
    assign room    = !m_valid_q || m_ready;

endmodule

// File: rtl/dmspi_csel.sv
module dmspi_csel
    import dmspi_pkg::*;
#(
    parameter int unsigned LAYERS = DEF_LAYERS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LAYERS-1:0] sw_sel,
    input  logic [LAYERS-1:0] auto_en,
    output logic              cs_n
);

    logic [LAYERS-1:0] lane_low;
    logic              cs_n_q;

    for (genvar g = 0; g < LAYERS; g++) begin : g_lane
        assign lane_low[g] = sw_sel[g] | auto_en[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= ~(|lane_low);
        end
    end

    assign cs_n = cs_n_q;

endmodule

// File: rtl/dmspi_master.sv
module dmspi_master
    import dmspi_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter int unsigned LAYERS = DEF_LAYERS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic [BYTE_W-1:0] s_data_i,
    output logic              m_valid_o,
    input  logic              m_ready_i,
    output logic [BYTE_W-1:0] m_data_o,
    input  logic              force_i,
    input  logic              miso_off_i,
    input  logic [LAYERS-1:0] cs_sel_i,
    input  logic [LAYERS-1:0] autoread_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso0_i,
    input  logic              miso1_i
);

    pulse_req_t pulse_req;
    logic       out_room;
    logic       cap_vld;
    lane_pair_t cap_pair;
    logic       rx_push;

    dmspi_sched #(.BYTE_W(BYTE_W)) sched_i (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (s_valid_i),
        .s_ready  (s_ready_o),
        .s_data   (s_data_i),
        .force_en (force_i),
        .room     (out_room),
        .req      (pulse_req),
        .mosi     (mosi_o)
    );

    dmspi_phy phy_i (
        .clk     (clk),
        .rst     (rst),
        .fire    (pulse_req.fire),
        .miso0   (miso0_i),
        .miso1   (miso1_i),
        .sclk    (sclk_o),
        .cap_vld (cap_vld),
        .cap     (cap_pair)
    );

    dmspi_assemble #(.BYTE_W(BYTE_W)) asm_i (
        .clk     (clk),
        .rst     (rst),
        .cap_vld (cap_vld),
        .cap     (cap_pair),
        .drop    (miso_off_i),
        .m_valid (m_valid_o),
        .m_ready (m_ready_i),
        .m_data  (m_data_o),
        .room    (out_room),
        .push    (rx_push)
    );

    dmspi_csel #(.LAYERS(LAYERS)) csel_i (
        .clk     (clk),
        .rst     (rst),
        .sw_sel  (cs_sel_i),
        .auto_en (autoread_i),
        .cs_n    (cs_n_o)
    );

endmodule

// File: rtl/dmspi_checker.sv
module dmspi_checker #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LAYERS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              m_valid,
    input logic              m_ready,
    input logic [BYTE_W-1:0] m_data,
    input logic              miso_off,
    input logic [LAYERS-1:0] cs_sel,
    input logic [LAYERS-1:0] auto_en,
    input logic              cs_n,
    input logic              push
);

    logic seen_rst_q;
    always_ff @(posedge clk) seen_rst_q <= rst;

    always @(posedge clk) begin
        if (seen_rst_q && !rst) begin
            assert_reset_idle_R1: assert (cs_n && !m_valid)
                else $error("R1: outputs not idle after reset");
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        push |-> (!m_valid || m_ready))
        else $error("R6: received byte pushed onto an occupied output");

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)))
        else $error("R10: stalled output changed");

    assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(m_valid) |-> !$past(miso_off))
        else $error("R7: byte presented while receive path disabled");

    assert_cs_auto_R9: assert property (@(posedge clk) disable iff (rst)
        (|auto_en) |=> !cs_n)
        else $error("R9: chip select high while autoread enabled");

    assert_cs_sel_R8: assert property (@(posedge clk) disable iff (rst)
        (|cs_sel) |=> !cs_n)
        else $error("R8: chip select high while a select bit is set");

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
        (!(|cs_sel) && !(|auto_en)) |=> cs_n)
        else $error("R8: chip select low with no request");

endmodule

bind dmspi_master dmspi_checker #(.BYTE_W(BYTE_W), .LAYERS(LAYERS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .m_valid  (m_valid_o),
    .m_ready  (m_ready_i),
    .m_data   (m_data_o),
    .miso_off (miso_off_i),
    .cs_sel   (cs_sel_i),
    .auto_en  (autoread_i),
    .cs_n     (cs_n_o),
    .push     (rx_push)
);

// File: tb/dmspi_master_tb_top.sv
`timescale 1ns/1ps
module dmspi_master_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       m_ready = 1'b1;
    logic       force_en = 1'b0;
    logic       miso_off = 1'b0;
    logic [2:0] cs_sel = 3'b000;
    logic [2:0] auto_en = 3'b000;
    logic       miso0 = 1'b0;
    logic       miso1 = 1'b0;
    logic       s_ready;
    logic       m_valid;
    logic [7:0] m_data;
    logic       sclk;
    logic       cs_n;
    logic       mosi;

    int n_chk  = 0;
    int n_fail = 0;
    int pulses = 0;
    int n_rx   = 0;
    logic       sent_bits [0:1023];
    logic [7:0] rx_bytes  [0:255];

    always #10 clk = ~clk;

    dmspi_master dut_i (
        .clk(clk), .rst(rst),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
        .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
        .force_i(force_en), .miso_off_i(miso_off),
        .cs_sel_i(cs_sel), .autoread_i(auto_en),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi),
        .miso0_i(miso0), .miso1_i(miso1)
    );

    function automatic logic [15:0] slave_word(input int n);
        return 16'(16'h1E2D + 16'(n) * 16'h0F13);
    endfunction

    function automatic logic [7:0] sent_byte(input int b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = sent_bits[8*b + i];
        return r;
    endfunction

    // sensor model: new bits on rising serial edge, MOSI recorded on falling
    initial begin
        logic [15:0] w;
        int k;
        forever begin
            @(posedge sclk);
            w = slave_word(pulses / 8);
            k = pulses % 8;
            miso0 <= w[2*k];
            miso1 <= w[2*k+1];
            @(negedge sclk);
            if (pulses < 1024) sent_bits[pulses] = mosi;
            pulses++;
        end
    end

    // output stream monitor
    initial begin
        forever begin
            @(negedge clk);
            if (m_valid && m_ready && n_rx < 256) begin
                rx_bytes[n_rx] = m_data;
                n_rx++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit got;
        s_valid = 1'b1;
        s_data  = b;
        do begin
            @(negedge clk);
            got = s_ready;
            @(posedge clk);
            #2;
        end while (!got);
        s_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        chk(cs_n === 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
        chk(m_valid === 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
        chk(mosi === 1'b0, "R1 mosi after reset", int'(mosi), 0);
        chk(sclk === 1'b0, "R1 sclk after reset", int'(sclk), 0);
    endtask

    task automatic t_idle;
        int p0 = pulses;
        tick(40);
        chk(pulses == p0, "R2 no pulses while idle", pulses - p0, 0);
        chk(m_valid === 1'b0, "R2 no output while idle", int'(m_valid), 0);
    endtask

    task automatic t_single;
        int p0 = pulses;
        int r0 = n_rx;
        int bi = pulses / 8;
        logic [15:0] w = slave_word(bi);
        send_byte(8'hA5);
        tick(30);
        chk(pulses - p0 == 8, "R2 eight pulses per byte", pulses - p0, 8);
        chk(sent_byte(bi) == 8'hA5, "R3 byte on mosi lsb first", int'(sent_byte(bi)), 'hA5);
        chk(n_rx - r0 == 2, "R4 two bytes back per byte", n_rx - r0, 2);
        chk(rx_bytes[r0] == w[7:0], "R4 first received byte", int'(rx_bytes[r0]), int'(w[7:0]));
        chk(rx_bytes[r0+1] == w[15:8], "R4 second received byte", int'(rx_bytes[r0+1]), int'(w[15:8]));
    endtask

    task automatic t_burst;
        int p0 = pulses;
        int r0 = n_rx;
        int bi = pulses / 8;
        logic [7:0] seq [3] = '{8'h01, 8'hFE, 8'h96};
        for (int i = 0; i < 3; i++) send_byte(seq[i]);
        tick(30);
        chk(pulses - p0 == 24, "R2 burst pulse count", pulses - p0, 24);
        for (int i = 0; i < 3; i++) begin
            logic [15:0] w = slave_word(bi + i);
            chk(sent_byte(bi + i) == seq[i], "R3 burst mosi byte", int'(sent_byte(bi + i)), int'(seq[i]));
            chk(rx_bytes[r0 + 2*i] == w[7:0], "R4 burst low byte", int'(rx_bytes[r0 + 2*i]), int'(w[7:0]));
            chk(rx_bytes[r0 + 2*i + 1] == w[15:8], "R4 burst high byte", int'(rx_bytes[r0 + 2*i + 1]), int'(w[15:8]));
        end
    endtask

    task automatic t_force;
        int p0 = pulses;
        int r0 = n_rx;
        int bi = pulses / 8;
        int nb;
        bit zeros = 1'b1;
        force_en = 1'b1;
        tick(20);
        force_en = 1'b0;
        tick(30);
        nb = (pulses - p0) / 8;
        chk((pulses - p0) > 0 && (pulses - p0) % 8 == 0, "R5 whole null bytes", pulses - p0, 8 * nb);
        for (int i = 0; i < nb; i++) if (sent_byte(bi + i) != 8'h00) zeros = 1'b0;
        chk(zeros, "R5 null bytes are zero", int'(zeros), 1);
        chk(n_rx - r0 == 2 * nb, "R5 reception during force", n_rx - r0, 2 * nb);
        // stream byte and force offered in the same cycle
        p0 = pulses;
        bi = pulses / 8;
        force_en = 1'b1;
        send_byte(8'h3C);
        force_en = 1'b0;
        tick(30);
        chk(pulses - p0 == 8, "R5 stream byte wins one byte", pulses - p0, 8);
        chk(sent_byte(bi) == 8'h3C, "R5 stream byte precedence", int'(sent_byte(bi)), 'h3C);
    endtask

    task automatic t_stall;
        int p0 = pulses;
        int r0 = n_rx;
        int bi = pulses / 8;
        logic [15:0] w = slave_word(bi);
        logic [7:0] held;
        m_ready = 1'b0;
        send_byte(8'h5A);
        tick(40);
        chk(pulses - p0 == 7, "R6 clock frozen before byte end", pulses - p0, 7);
        chk(m_valid === 1'b1, "R6 first byte held", int'(m_valid), 1);
        chk(m_data == w[7:0], "R6 held byte value", int'(m_data), int'(w[7:0]));
        held = m_data;
        tick(10);
        chk(m_valid === 1'b1 && m_data == held, "R10 output stable while stalled", int'(m_data), int'(held));
        chk(pulses - p0 == 7, "R6 clock stays frozen", pulses - p0, 7);
        m_ready = 1'b1;
        tick(20);
        chk(pulses - p0 == 8, "R6 clock resumes", pulses - p0, 8);
        chk(n_rx - r0 == 2, "R6 no byte lost", n_rx - r0, 2);
        chk(rx_bytes[r0] == w[7:0] && rx_bytes[r0+1] == w[15:8], "R6 order kept",
            int'({rx_bytes[r0], rx_bytes[r0+1]}), int'({w[7:0], w[15:8]}));
    endtask

    task automatic t_miso_off;
        int p0 = pulses;
        int r0 = n_rx;
        int bi;
        logic [15:0] w;
        bit rose = 1'b0;
        miso_off = 1'b1;
        send_byte(8'hC7);
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (m_valid) rose = 1'b1;
        end
        chk(pulses - p0 == 8, "R7 transmit continues", pulses - p0, 8);
        chk(!rose && n_rx == r0, "R7 received bytes dropped", n_rx - r0, 0);
        miso_off = 1'b0;
        r0 = n_rx;
        bi = pulses / 8;
        w = slave_word(bi);
        send_byte(8'h24);
        tick(30);
        chk(n_rx - r0 == 2 && rx_bytes[r0] == w[7:0] && rx_bytes[r0+1] == w[15:8],
            "R7 reception back after enable", int'({rx_bytes[r0], rx_bytes[r0+1]}), int'({w[7:0], w[15:8]}));
    endtask

    task automatic t_cs;
        cs_sel = 3'b010;
        tick(2);
        chk(cs_n === 1'b0, "R8 select bit lowers cs", int'(cs_n), 0);
        cs_sel = 3'b000;
        tick(2);
        chk(cs_n === 1'b1, "R8 cleared select raises cs", int'(cs_n), 1);
        cs_sel = 3'b100;
        tick(2);
        chk(cs_n === 1'b0, "R8 any layer select", int'(cs_n), 0);
        cs_sel = 3'b000;
        auto_en = 3'b001;
        tick(2);
        chk(cs_n === 1'b0, "R9 autoread lowers cs", int'(cs_n), 0);
        cs_sel = 3'b001;
        tick(2);
        cs_sel = 3'b000;
        auto_en = 3'b010;
        tick(2);
        chk(cs_n === 1'b0, "R9 cs low while any autoread", int'(cs_n), 0);
        auto_en = 3'b000;
        tick(2);
        chk(cs_n === 1'b1, "R9 cs high after autoread cleared", int'(cs_n), 1);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_single();
        t_burst();
        t_force();
        t_stall();
        t_miso_off();
        t_cs();
        t_idle();
        summary();
        $finish;
    end

endmodule